// File: doc/BRIEF.md
# Shader Program Store and Sequencer

This block keeps the instruction store of a vertex-shader engine and walks a program through it. A host loads programs one 32-bit word at a time. An upload-base command sets the slot that the next instruction goes to. Each group of four words then forms one 128-bit instruction, and the slot pointer moves on by one after each instruction. A separate entry-slot command records where execution will begin. Subroutines can therefore be loaded anywhere, including below the main routine.

A run pulse starts execution at the entry slot. The sequencer presents one instruction per cycle together with its slot index. It follows conditional jumps and subroutine calls, using a condition-test result supplied from outside. Returns come from a small return stack. The arithmetic units and register files that consume the presented instruction live elsewhere. Execution ends on an instruction carrying the end flag, or on a return-stack fault.

Top module: `shprog_seq`

## Requirements
- R1: After reset, busy, done, stack_err and exec_vld are all low.
- R2: Words are taken in order word 0 first. Word k fills instruction bits 32k+31:32k, and the whole instruction is stored when word 3 arrives.
- R3: An upload-base command loads the slot pointer and restarts the word count. A base command and a word in the same cycle keep the base and drop the word. Each stored instruction advances the pointer by one, wrapping at the store size.
- R4: The entry-slot command is accepted at any time. A run pulse given while idle starts execution at the entry slot held before that edge, with exec_vld high from the next cycle.
- R5: While running, exec_pc and exec_inst show the current slot and its contents. An instruction that is not a taken jump, a call or a return moves to slot+1.
- R6: The operation field is bits 27:23 of word 1. Value 16 is a jump. When cond_pass is high it goes to the target held in bits 10:2 of word 2; otherwise it falls through. A backward jump forms a loop.
- R7: Value 17 is a call. When cond_pass is high it pushes slot+1 and goes to the target; otherwise it falls through. Value 18 is a return: it pops the stack and goes there, regardless of cond_pass.
- R8: The return stack holds 4 entries. A call with the stack full, or a return with the stack empty, raises stack_err and stops execution without a done pulse. stack_err stays high until the next accepted run, which also empties the stack.
- R9: An instruction with bit 0 of word 3 set is the last one. Execution stops after it, done is high for exactly the following cycle, and the end flag takes precedence over any operation in that instruction.
- R10: busy equals exec_vld. While busy is high, base commands and words are ignored.
- R11: A run pulse while busy has no effect on the current execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_base_vld | input | 1 | Load the upload slot pointer |
| up_base_idx | input | 9 | New upload slot |
| up_word_vld | input | 1 | Instruction word valid |
| up_word | input | 32 | Instruction word |
| entry_vld | input | 1 | Load the entry slot |
| entry_idx | input | 9 | Entry slot for the next run |
| run | input | 1 | Start pulse |
| cond_pass | input | 1 | External condition-test result |
| exec_vld | output | 1 | An instruction is being presented |
| exec_pc | output | 9 | Slot of the presented instruction |
| exec_inst | output | 128 | Presented instruction |
| busy | output | 1 | Execution in progress |
| done | output | 1 | One-cycle pulse after the last instruction |
| stack_err | output | 1 | Sticky return-stack fault |

## Verification
Two functions can coincide in one cycle. The first is the store being written while the sequencer is launched or reads from it. The bench delivers the final word of an instruction in the same cycle as the run pulse, aimed at the entry slot, and expects that new instruction to be the first one shown. The second is uploads and entry commands arriving during a run. The bench sends a base command and a full instruction while a loop is executing, plus a second run pulse and a new entry slot. It then judges by later runs that the uploads left nothing behind and the new entry took effect only at the next launch. A cycle-level model in the bench compares every output on every clock.

// File: rtl/shprog_pkg.sv
package shprog_pkg;
  localparam int WORD_W   = 32;
  localparam int WORDS    = 4;
  localparam int INST_W   = WORD_W * WORDS;
  localparam int OP_LSB   = 32 + 23;
  localparam int OP_W     = 5;
  localparam int TGT_LSB  = 64 + 2;
  localparam int END_BIT  = 96;
  localparam logic [OP_W-1:0] OP_JMP = 5'd16;
  localparam logic [OP_W-1:0] OP_CAL = 5'd17;
  localparam logic [OP_W-1:0] OP_RET = 5'd18;
endpackage

// File: rtl/shprog_loader.sv
module shprog_loader #(
  parameter int IDX_W  = 9,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    busy,
  input  logic                    base_vld,
  input  logic [IDX_W-1:0]        base_idx,
  input  logic                    word_vld,
  input  logic [WORD_W-1:0]       word_data,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [WORD_W*WORDS-1:0] wr_data
);
  localparam int CNT_W = $clog2(WORDS);
  localparam int BUF_W = WORD_W * (WORDS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [BUF_W-1:0] buf_q;
  logic             take_base, take_word, last_word, cnt_en, ptr_en;

  always_comb begin
    take_base = base_vld && !busy;
    take_word = word_vld && !busy && !base_vld;
    last_word = take_word && (cnt_q == CNT_W'(WORDS - 1));
    cnt_d = cnt_q;
    ptr_d = ptr_q;
    if (take_base) begin
      cnt_d = '0;
      ptr_d = base_idx;
    end else if (last_word) begin
      cnt_d = '0;
      ptr_d = ptr_q + 1'b1;
    end else if (take_word) begin
      cnt_d = cnt_q + 1'b1;
    end
    cnt_en = take_base || take_word;
    ptr_en = take_base || last_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < WORDS - 1; g++) begin : g_wbuf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        buf_q[g*WORD_W +: WORD_W] <= '0;
      else if (take_word && cnt_q == CNT_W'(g))
        buf_q[g*WORD_W +: WORD_W] <= word_data;
    end
  end

  assign wr_en   = last_word;
  assign wr_idx  = ptr_q;
  assign wr_data = {word_data, buf_q};

  assert_wptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q == IDX_W'($past(ptr_q) + 1'b1));

  assert_upload_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ptr_q) && $stable(cnt_q)));
endmodule

// File: rtl/shprog_store.sv
module shprog_store #(
  parameter int IDX_W  = 9,
  parameter int INST_W = 128
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [INST_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [INST_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [INST_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/shprog_retstack.sv
module shprog_retstack #(
  parameter int IDX_W = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic [IDX_W-1:0] push_val,
  output logic [IDX_W-1:0] top,
  output logic             full,
  output logic             empty
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] slot_q [DEPTH];
  logic             cnt_en;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)               cnt_d = '0;
    else if (push && !full)  cnt_d = cnt_q + 1'b1;
    else if (pop && !empty)  cnt_d = cnt_q - 1'b1;
    cnt_en = clear || push || pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (push && !clear && cnt_q == CNT_W'(g))
        slot_q[g] <= push_val;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) top = slot_q[i];
    end
  end

  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_push_pop_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/shprog_core.sv
module shprog_core
  import shprog_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             entry_vld,
  input  logic [IDX_W-1:0] entry_idx,
  input  logic             cond_pass,
  input  logic [OP_W-1:0]  op,
  input  logic [IDX_W-1:0] tgt,
  input  logic             last,
  input  logic [IDX_W-1:0] stk_top,
  input  logic             stk_full,
  input  logic             stk_empty,
  output logic             stk_push,
  output logic             stk_pop,
  output logic             stk_clear,
  output logic [IDX_W-1:0] stk_val,
  output logic [IDX_W-1:0] pc,
  output logic             running,
  output logic             done,
  output logic             stack_err
);
  logic [IDX_W-1:0] pc_q, pc_d, entry_q, pc_inc;
  logic             run_q, run_d, done_q, done_d, err_q, err_d;
  logic             pc_en, run_en, err_en;

  always_comb begin
    pc_inc    = pc_q + 1'b1;
    pc_d      = pc_q;
    run_d     = run_q;
    done_d    = 1'b0;
    err_d     = err_q;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;
    stk_clear = 1'b0;
    if (run_q) begin
      if (last) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end else if (op == OP_JMP && cond_pass) begin
        pc_d = tgt;
      end else if (op == OP_CAL && cond_pass) begin
        if (stk_full) begin
          err_d = 1'b1;
          run_d = 1'b0;
        end else begin
          stk_push = 1'b1;
          pc_d     = tgt;
        end
      end else if (op == OP_RET) begin
        if (stk_empty) begin
          err_d = 1'b1;
          run_d = 1'b0;
        end else begin
          stk_pop = 1'b1;
          pc_d    = stk_top;
        end
      end else begin
        pc_d = pc_inc;
      end
    end else if (run) begin
      run_d     = 1'b1;
      pc_d      = entry_q;
      err_d     = 1'b0;
      stk_clear = 1'b1;
    end
    pc_en  = run_q || run;
    run_en = run_q || run;
    err_en = run_q || run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (run_en) run_q <= run_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         entry_q <= '0;
    else if (entry_vld) entry_q <= entry_idx;
  end

  assign stk_val   = pc_inc;
  assign pc        = pc_q;
  assign running   = run_q;
  assign done      = done_q;
  assign stack_err = err_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_after_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!run_q && $past(run_q)));

  assert_err_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (!run_q && !done_q));

  assert_run_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run && !last && op != OP_JMP && op != OP_CAL && op != OP_RET)
      |=> (run_q && pc_q == IDX_W'($past(pc_q) + 1'b1)));
endmodule

// File: rtl/shprog_seq.sv
module shprog_seq
  import shprog_pkg::*;
#(
  parameter int IDX_W     = 9,
  parameter int STK_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_base_vld,
  input  logic [IDX_W-1:0]  up_base_idx,
  input  logic              up_word_vld,
  input  logic [WORD_W-1:0] up_word,
  input  logic              entry_vld,
  input  logic [IDX_W-1:0]  entry_idx,
  input  logic              run,
  input  logic              cond_pass,
  output logic              exec_vld,
  output logic [IDX_W-1:0]  exec_pc,
  output logic [INST_W-1:0] exec_inst,
  output logic              busy,
  output logic              done,
  output logic              stack_err
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              wr_en, running, stk_push, stk_pop, stk_clear, stk_full, stk_empty;
  logic [IDX_W-1:0]  wr_idx, pc, stk_top, stk_val;
  logic [INST_W-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  shprog_loader #(.IDX_W(IDX_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_loader (
    .clk(clk), .rst_n(rst_core_n), .busy(running),
    .base_vld(up_base_vld), .base_idx(up_base_idx),
    .word_vld(up_word_vld), .word_data(up_word),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data));

  shprog_store #(.IDX_W(IDX_W), .INST_W(INST_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(pc), .rd_data(rd_data));

  shprog_retstack #(.IDX_W(IDX_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_core_n), .clear(stk_clear), .push(stk_push),
    .pop(stk_pop), .push_val(stk_val), .top(stk_top),
    .full(stk_full), .empty(stk_empty));

  shprog_core #(.IDX_W(IDX_W)) u_core (
    .clk(clk), .rst_n(rst_core_n), .run(run),
    .entry_vld(entry_vld), .entry_idx(entry_idx), .cond_pass(cond_pass),
    .op(rd_data[OP_LSB +: OP_W]), .tgt(rd_data[TGT_LSB +: IDX_W]),
    .last(rd_data[END_BIT]),
    .stk_top(stk_top), .stk_full(stk_full), .stk_empty(stk_empty),
    .stk_push(stk_push), .stk_pop(stk_pop), .stk_clear(stk_clear),
    .stk_val(stk_val), .pc(pc), .running(running), .done(done),
    .stack_err(stack_err));

  assign exec_vld  = running;
  assign busy      = running;
  assign exec_pc   = pc;
  assign exec_inst = rd_data;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (!busy && !done && !stack_err));
endmodule

// File: tb/sim_shprog_seq.sv
`timescale 1ns/1ps
module sim_shprog_seq;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         up_base_vld, up_word_vld, entry_vld, run, cond_pass;
  logic [8:0]   up_base_idx, entry_idx;
  logic [31:0]  up_word;
  logic         exec_vld, busy, done, stack_err;
  logic [8:0]   exec_pc;
  logic [127:0] exec_inst;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit chk_on = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  shprog_seq u0 (
    .clk(clk), .rst_n(rst_n), .up_base_vld(up_base_vld), .up_base_idx(up_base_idx),
    .up_word_vld(up_word_vld), .up_word(up_word), .entry_vld(entry_vld),
    .entry_idx(entry_idx), .run(run), .cond_pass(cond_pass),
    .exec_vld(exec_vld), .exec_pc(exec_pc), .exec_inst(exec_inst),
    .busy(busy), .done(done), .stack_err(stack_err));

  // behavioural reference
  bit [127:0] m_mem [int];
  int         m_stk [$];
  logic [8:0] m_pc, m_entry, m_wptr;
  int         m_cnt;
  logic [31:0] m_buf [3];
  bit         m_run, m_done, m_err, m_was;
  bit [127:0] m_ci;

  function automatic bit [127:0] m_rd(int a);
    if (m_mem.exists(a)) return m_mem[a];
    return '0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_err = 0; m_pc = 0; m_entry = 0; m_wptr = 0; m_cnt = 0;
      m_stk.delete();
    end else begin
      m_was = m_run;
      m_done = 0;
      if (m_run) begin
        m_ci = m_rd(int'(m_pc));
        if (m_ci[96]) begin
          m_run = 0; m_done = 1;
        end else if (m_ci[59:55] == 5'd16 && cond_pass) begin
          m_pc = m_ci[74:66];
        end else if (m_ci[59:55] == 5'd17 && cond_pass) begin
          if (m_stk.size() == 4) begin m_err = 1; m_run = 0; end
          else begin m_stk.push_back(int'(m_pc) + 1); m_pc = m_ci[74:66]; end
        end else if (m_ci[59:55] == 5'd18) begin
          if (m_stk.size() == 0) begin m_err = 1; m_run = 0; end
          else m_pc = 9'(m_stk.pop_back());
        end else begin
          m_pc = m_pc + 9'd1;
        end
      end else if (run) begin
        m_run = 1; m_pc = m_entry; m_err = 0; m_stk.delete();
      end
      if (entry_vld) m_entry = entry_idx;
      if (!m_was) begin
        if (up_base_vld) begin
          m_wptr = up_base_idx; m_cnt = 0;
        end else if (up_word_vld) begin
          if (m_cnt == 3) begin
            m_mem[int'(m_wptr)] = {up_word, m_buf[2], m_buf[1], m_buf[0]};
            m_wptr = m_wptr + 9'd1; m_cnt = 0;
          end else begin
            m_buf[m_cnt] = up_word; m_cnt++;
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (chk_on) begin
      chk(busy === m_run, {"R10/", phase}, "busy", 128'(busy), 128'(m_run));
      chk(exec_vld === m_run, {"R4/", phase}, "exec_vld", 128'(exec_vld), 128'(m_run));
      chk(done === m_done, {"R9/", phase}, "done", 128'(done), 128'(m_done));
      chk(stack_err === m_err, {"R8/", phase}, "stack_err", 128'(stack_err), 128'(m_err));
      if (m_run) begin
        chk(exec_pc === m_pc, {"R5/", phase}, "exec_pc", 128'(exec_pc), 128'(m_pc));
        chk(exec_inst === m_rd(int'(m_pc)), {"R2/", phase}, "exec_inst", exec_inst, m_rd(int'(m_pc)));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit [127:0] mk(bit [4:0] op, bit [8:0] tg, bit last, bit [15:0] tag);
    bit [127:0] i = '0;
    i[59:55]  = op;
    i[74:66]  = tg;
    i[96]     = last;
    i[23:8]   = tag;
    i[127:112] = ~tag;
    return i;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic set_base(bit [8:0] a);
    up_base_vld = 1; up_base_idx = a; tick(); up_base_vld = 0;
  endtask

  task automatic send_word(bit [31:0] w);
    up_word_vld = 1; up_word = w; tick(); up_word_vld = 0;
  endtask

  task automatic send_inst(bit [127:0] i);
    for (int k = 0; k < 4; k++) send_word(i[32*k +: 32]);
  endtask

  task automatic set_entry(bit [8:0] a);
    entry_vld = 1; entry_idx = a; tick(); entry_vld = 0;
  endtask

  task automatic go(); run = 1; tick(); run = 0; endtask

  task automatic wait_idle();
    int n = 0;
    tick();
    while (busy && n < 3000) begin tick(); n++; end
    tick();
  endtask

  initial begin
    rst_n = 0; up_base_vld = 0; up_word_vld = 0; entry_vld = 0; run = 0; cond_pass = 0;
    up_base_idx = '0; entry_idx = '0; up_word = '0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R1: reset state
    chk(!busy && !done && !stack_err && !exec_vld, "R1", "reset outputs",
        128'({busy, done, stack_err, exec_vld}), 128'(0));
    chk(busy === 1'b0, "R1", "busy after reset", 128'(busy), 128'(0));
    chk_on = 1;

    // R7: call into a subroutine loaded below the main routine, then return
    phase = "R7";
    set_base(9'd10);
    send_inst(mk(5'd0, 9'd0, 0, 16'hA10));
    send_inst(mk(5'd18, 9'd0, 0, 16'hA11));
    send_inst(mk(5'd17, 9'd10, 0, 16'hA12));
    send_inst(mk(5'd0, 9'd0, 0, 16'hA13));
    send_inst(mk(5'd17, 9'd10, 1, 16'hA14));   // R9: end flag wins over call
    set_entry(9'd12);
    cond_pass = 1;
    go();
    wait_idle();
    chk(stack_err === 1'b0, "R9", "no fault after end", 128'(stack_err), 128'(0));

    // R6: backward jump loop with uploads arriving mid-run (R10)
    phase = "R6";
    set_base(9'd20);
    send_inst(mk(5'd0, 9'd0, 0, 16'hB20));
    send_inst(mk(5'd16, 9'd20, 0, 16'hB21));
    send_inst(mk(5'd0, 9'd0, 1, 16'hB22));
    set_entry(9'd20);
    cond_pass = 1;
    go();
    phase = "R10";
    set_base(9'd40);
    send_inst(mk(5'd0, 9'd0, 1, 16'hDEAD));
    phase = "R11";
    set_entry(9'd12);
    go();                                     // run while busy: ignored
    repeat (3) tick();
    phase = "R6";
    cond_pass = 0;
    wait_idle();

    // R3: pointer continues at 23 since the mid-run base was dropped
    phase = "R3";
    send_inst(mk(5'd0, 9'd0, 1, 16'hC23));
    set_entry(9'd23);
    go();
    wait_idle();
    chk(m_mem.exists(23) && !m_mem.exists(40), "R3", "model pointer", 128'(m_wptr), 128'(24));
    // partial upload then base restart
    set_base(9'd50);
    send_word(32'h1111_1111);
    send_word(32'h2222_2222);
    set_base(9'd50);
    // base and word in the same cycle: word dropped
    up_base_vld = 1; up_base_idx = 9'd50; up_word_vld = 1; up_word = 32'h3333_3333;
    tick();
    up_base_vld = 0; up_word_vld = 0;
    send_inst(mk(5'd0, 9'd0, 1, 16'hC50));
    set_entry(9'd50);
    go();                                     // R12 model: runs slot 12 entry? no, entry 50
    wait_idle();

    // R8: overflow by recursive call, then underflow
    phase = "R8";
    set_base(9'd30);
    send_inst(mk(5'd17, 9'd30, 0, 16'hD30));
    send_inst(mk(5'd18, 9'd0, 0, 16'hD31));
    set_entry(9'd30);
    cond_pass = 1;
    go();
    wait_idle();
    chk(stack_err === 1'b1, "R8", "overflow flag", 128'(stack_err), 128'(1));
    repeat (3) tick();
    chk(stack_err === 1'b1, "R8", "flag sticky", 128'(stack_err), 128'(1));
    set_entry(9'd31);
    go();
    wait_idle();
    chk(stack_err === 1'b1, "R8", "underflow flag", 128'(stack_err), 128'(1));
    set_entry(9'd12);
    go();
    wait_idle();
    chk(stack_err === 1'b0, "R8", "cleared by run", 128'(stack_err), 128'(0));

    // R4/R2 same cycle: last word stored while run launches at that slot
    phase = "R4";
    set_entry(9'd60);
    set_base(9'd60);
    begin
      bit [127:0] ni = mk(5'd0, 9'd0, 1, 16'hE60);
      for (int k = 0; k < 3; k++) send_word(ni[32*k +: 32]);
      up_word_vld = 1; up_word = ni[127:96]; run = 1;
      tick();
      up_word_vld = 0; run = 0;
      chk(exec_inst === ni, "R4", "first inst is fresh upload", exec_inst, ni);
      chk(exec_pc === 9'd60, "R4", "entry slot", 128'(exec_pc), 128'(60));
    end
    wait_idle();

    // R5: fall-through of a not-taken call and jump
    phase = "R5";
    set_base(9'd70);
    send_inst(mk(5'd17, 9'd10, 0, 16'hF70));
    send_inst(mk(5'd16, 9'd70, 0, 16'hF71));
    send_inst(mk(5'd0, 9'd0, 1, 16'hF72));
    set_entry(9'd70);
    cond_pass = 0;
    go();
    wait_idle();

    chk_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule